// File: doc/BRIEF.md
# Multi-Channel Buffered PWM Timer

This block generates several pulse-width-modulated outputs from one shared time base. A single 16-bit counter, advanced through a power-of-two prescaler, runs from zero up to a shared period value. Each output channel compares the counter with its own threshold and turns the result into an output level, which may be normal, inverted or forced inactive. The counter can also run in a symmetric up/down fashion. In that mode the period and threshold registers are only swapped at the top of the count.

Software reaches the block over a simple strobed register bus: an 8-bit address, 32-bit write data, a write strobe and a read strobe. Read data is registered. Period and threshold writes are double-buffered while the counter runs. Each new value waits in a shadow register until the counter passes the period boundary. Readback always returns the value currently in force, so a driver can poll until its update has landed. When the counter is stopped, writes act at once. Each channel keeps a sticky match flag, which software clears by writing one to it.

Top module: `shared_pwm_timer`

## Requirements
- R1: After synchronous reset every output is low, and the control, counter, period, threshold and channel control registers all read 0.
- R2: Address 0x04 reads the channel count in bits [7:0] and zero above.
- R3: With control bits [4:3] = 1 and bit 5 = 0, the counter advances once every 2^P clocks, where P is control bits [2:0]. It counts 0, 1, … up to the period value and then wraps to 0, so one period is (period+1)·2^P clocks.
- R4: Control bits [4:3] equal to 0, 2 or 3 stop the counter, which then holds its value. A write to the counter register at 0x14 loads bits [15:0] into the counter.
- R5: While the counter is stopped, writes to the period register (0x18) and to a channel threshold register (0x24+8n) take effect in the next cycle and read back at once.
- R6: While the counter runs in edge-aligned mode, period and threshold writes are held back until the counter next wraps from the period value to 0. Until then, readback returns the old value, and the period in progress keeps its old length.
- R7: With control bit 5 = 1, the counter counts up to the period value and then back down to 0. Held period and threshold values are applied when the count leaves the period value toward period−1.
- R8: With a channel's level field (bits [3:2] of 0x20+8n) equal to 2, the output is high exactly while the counter is below the threshold. A threshold of 0 gives a constantly low output, and a threshold above the period value gives a constantly high output.
- R9: A level field of 1 gives the complement of the R8 output. A level field of 0 or 3 holds the output low. A change of the level field takes effect in the cycle after the write, without waiting for a period boundary.
- R10: A channel's flag (bit 7 of its control register) becomes 1 after a cycle in which the counter runs and equals that channel's active threshold. The flag stays 1 until a control write with bit 7 = 1 clears it. It does not set while the counter is stopped.
- R11: Read data appears on the clock edge at which the read strobe is sampled. A channel control register reads back {flag, 0, bits [5:4] as written, level, 00}. Unmapped addresses, misaligned channel addresses and channels at or above the channel count read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The threshold is swept across every value from 0 to two past the period, with high time counted over one full period. This separates 0 %, partial and 100 % duty, and shows that normal and inverted channels stay complementary. A prescaler sweep counts high time over a whole scaled period, which separates a correct divide ratio from a wrong one. Writes are issued both with the counter stopped and with it running. Readback and a flag that can only set late in the period show whether a value was applied at once, at the wrap, or too early. The up/down mode is run with a known threshold to tell its triangle count from a sawtooth.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int CNT_W  = 16;
    localparam int PS_W   = 3;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_INFO    = 8'h04;
    localparam logic [ADDR_W-1:0] A_CTRL    = 8'h10;
    localparam logic [ADDR_W-1:0] A_COUNT   = 8'h14;
    localparam logic [ADDR_W-1:0] A_PERIOD  = 8'h18;
    localparam logic [ADDR_W-1:0] A_CH_BASE = 8'h20;

    typedef enum logic [1:0] {
        CLK_OFF       = 2'd0,
        CLK_PRESCALED = 2'd1,
        CLK_RSVD2     = 2'd2,
        CLK_RSVD3     = 2'd3
    } clk_sel_e;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'd0,
        LVL_INV  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_RSVD = 2'd3
    } out_lvl_e;

    typedef struct packed {
        logic            center;
        clk_sel_e        clk_sel;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    typedef struct packed {
        logic [1:0] msel;
        out_lvl_e   lvl;
    } chan_cfg_t;

    function automatic logic drive_level(out_lvl_e lvl, logic below);
        case (lvl)
            LVL_HIGH: return below;
            LVL_INV:  return !below;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] chan_word(logic flag, chan_cfg_t cfg);
        return {{(DATA_W-8){1'b0}}, flag, 1'b0, cfg, 2'b00};
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_tmr_pkg::*;
#(
    parameter int PSW = PS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           clr,
    input  logic [PSW-1:0] ps,
    output logic           tick
);
    localparam int DIV_W = (1 << PSW) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    assign limit = {DIV_W{1'b1}} >> (DIV_W - int'(ps));
    assign tick  = run && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run || clr || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          center,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_val,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          reload
);
    logic [CW-1:0] cnt_d;
    logic          down_q, down_d, edge_evt;

    always_comb begin
        cnt_d    = cnt;
        down_d   = down_q;
        edge_evt = 1'b0;
        if (wr_en) begin
            cnt_d  = wr_val;
            down_d = 1'b0;
        end else if (tick) begin
            if (!center) begin
                down_d = 1'b0;
                if (cnt >= period) begin
                    cnt_d    = '0;
                    edge_evt = 1'b1;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end else if (!down_q) begin
                if (cnt >= period) begin
                    edge_evt = 1'b1;
                    if (period == '0) begin
                        cnt_d = '0;
                    end else begin
                        cnt_d  = period - 1'b1;
                        down_d = 1'b1;
                    end
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end else begin
                if (cnt == '0) begin
                    down_d = 1'b0;
                    cnt_d  = (period == '0) ? '0 : CW'(1);
                end else begin
                    cnt_d = cnt - 1'b1;
                end
            end
        end
    end

    assign reload = edge_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            down_q <= 1'b0;
        end else begin
            cnt    <= cnt_d;
            down_q <= down_d;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          running,
    input  logic [CW-1:0] cnt,
    input  logic          reload,
    input  logic          thr_wr,
    input  logic [CW-1:0] thr_val,
    input  logic          cfg_wr,
    input  chan_cfg_t     cfg_in,
    input  logic          flag_clr,
    output logic [CW-1:0] thr_act,
    output chan_cfg_t     cfg,
    output logic          flag,
    output logic          pwm
);
    logic [CW-1:0] thr_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_buf <= '0;
            thr_act <= '0;
        end else begin
            if (reload) begin
                thr_act <= thr_buf;
            end
            if (thr_wr) begin
                thr_buf <= thr_val;
                if (!running) begin
                    thr_act <= thr_val;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            cfg <= cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (running && (cnt == thr_act)) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    assign pwm = drive_level(cfg.lvl, cnt < thr_act);
endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer
    import pwm_tmr_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    localparam int IDX_W = ADDR_W - 3;

    ctrl_t                       ctrl_q;
    logic                        running, center, tick, reload;
    logic                        cnt_wr, per_wr, ctrl_wr;
    logic [CNT_W-1:0]            cnt_q, mod_buf, mod_act;
    logic [ADDR_W-1:0]           ch_off;
    logic [IDX_W-1:0]            ch_idx;
    logic                        ch_hit;
    logic [NCH-1:0]              thr_wr, cfg_wr, flag_clr, flag_v;
    logic [NCH-1:0][CNT_W-1:0]   cmp_act_v;
    chan_cfg_t [NCH-1:0]         cfg_v;
    logic [NCH-1:0][1:0]         lvl_v;
    logic [DATA_W-1:0]           rd_val;

    assign running = (ctrl_q.clk_sel == CLK_PRESCALED);
    assign center  = ctrl_q.center;
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign cnt_wr  = bus_wr && (bus_addr == A_COUNT);
    assign per_wr  = bus_wr && (bus_addr == A_PERIOD);

    assign ch_off = bus_addr - A_CH_BASE;
    assign ch_idx = ch_off[ADDR_W-1:3];
    assign ch_hit = (bus_addr >= A_CH_BASE) && (ch_off[1:0] == 2'b00)
                    && (int'(ch_idx) < NCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_buf <= '0;
            mod_act <= '0;
        end else begin
            if (reload) begin
                mod_act <= mod_buf;
            end
            if (per_wr) begin
                mod_buf <= bus_wdata[CNT_W-1:0];
                if (!running) begin
                    mod_act <= bus_wdata[CNT_W-1:0];
                end
            end
        end
    end

    pwm_prescaler #(.PSW(PS_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .clr  (cnt_wr),
        .ps   (ctrl_q.ps),
        .tick (tick)
    );

    pwm_counter #(.CW(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .center (center),
        .wr_en  (cnt_wr),
        .wr_val (bus_wdata[CNT_W-1:0]),
        .period (mod_act),
        .cnt    (cnt_q),
        .reload (reload)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        assign sel         = bus_wr && ch_hit && (ch_idx == IDX_W'(i));
        assign thr_wr[i]   = sel && ch_off[2];
        assign cfg_wr[i]   = sel && !ch_off[2];
        assign flag_clr[i] = cfg_wr[i] && bus_wdata[7];
        assign lvl_v[i]    = cfg_v[i].lvl;

        pwm_channel #(.CW(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .running  (running),
            .cnt      (cnt_q),
            .reload   (reload),
            .thr_wr   (thr_wr[i]),
            .thr_val  (bus_wdata[CNT_W-1:0]),
            .cfg_wr   (cfg_wr[i]),
            .cfg_in   (chan_cfg_t'(bus_wdata[5:2])),
            .flag_clr (flag_clr[i]),
            .thr_act  (cmp_act_v[i]),
            .cfg      (cfg_v[i]),
            .flag     (flag_v[i]),
            .pwm      (pwm_out[i])
        );
    end

    always_comb begin
        rd_val = '0;
        if (bus_addr == A_INFO) begin
            rd_val = DATA_W'(NCH);
        end else if (bus_addr == A_CTRL) begin
            rd_val = DATA_W'(ctrl_q);
        end else if (bus_addr == A_COUNT) begin
            rd_val = DATA_W'(cnt_q);
        end else if (bus_addr == A_PERIOD) begin
            rd_val = DATA_W'(mod_act);
        end else if (ch_hit) begin
            for (int i = 0; i < NCH; i++) begin
                if (ch_idx == IDX_W'(i)) begin
                    rd_val = ch_off[2] ? DATA_W'(cmp_act_v[i])
                                       : chan_word(flag_v[i], cfg_v[i]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/shared_pwm_timer_chk.sv
module shared_pwm_timer_chk #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    running,
    input logic                    tick,
    input logic                    center,
    input logic                    reload,
    input logic                    cnt_wr,
    input logic [CW-1:0]           cnt_q,
    input logic [CW-1:0]           mod_act,
    input logic [NCH-1:0]          flag_v,
    input logic [NCH-1:0][1:0]     lvl_v,
    input logic [NCH-1:0][CW-1:0]  cmp_act_v,
    input logic [NCH-1:0]          pwm_out
);
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (pwm_out == '0));

    p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
        tick |-> running);

    p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !center && (cnt_q >= mod_act) && !cnt_wr) |=> (cnt_q == '0));

    p_stop_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!running && !cnt_wr) |=> $stable(cnt_q));

    p_period_held_r6: assert property (@(posedge clk) disable iff (rst)
        (running && !reload) |=> $stable(mod_act));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_zero_duty_r8: assert property (@(posedge clk) disable iff (rst)
            ((lvl_v[i] == 2'd2) && (cmp_act_v[i] == '0)) |-> !pwm_out[i]);

        p_forced_low_r9: assert property (@(posedge clk) disable iff (rst)
            ((lvl_v[i] == 2'd0) || (lvl_v[i] == 2'd3)) |-> !pwm_out[i]);

        p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
            (running && (cnt_q == cmp_act_v[i])) |=> flag_v[i]);
    end
endmodule

bind shared_pwm_timer shared_pwm_timer_chk #(.NCH(NCH), .CW(pwm_tmr_pkg::CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .running   (running),
    .tick      (tick),
    .center    (center),
    .reload    (reload),
    .cnt_wr    (cnt_wr),
    .cnt_q     (cnt_q),
    .mod_act   (mod_act),
    .flag_v    (flag_v),
    .lvl_v     (lvl_v),
    .cmp_act_v (cmp_act_v),
    .pwm_out   (pwm_out)
);

// File: tb/shared_pwm_timer_bench.sv
module shared_pwm_timer_bench;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shared_pwm_timer #(.NCH(NCH)) u_shared_pwm_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic count_high(input int n, output int hi [NCH]);
        for (int k = 0; k < NCH; k++) hi[k] = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            for (int k = 0; k < NCH; k++) if (pwm_out[k]) hi[k]++;
        end
    endtask

    function automatic logic [7:0] ch_ctl(input int n);
        return 8'(8'h20 + 8 * n);
    endfunction

    function automatic logic [7:0] ch_thr(input int n);
        return 8'(8'h24 + 8 * n);
    endfunction

    task automatic stop_and_clear(input int period);
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'(period));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int hi [NCH];

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 outputs", pwm_out, 0);
        rd(8'h10, v); chk("R1 ctrl", v, 0);
        rd(8'h18, v); chk("R1 period", v, 0);
        rd(8'h14, v); chk("R1 count", v, 0);
        rd(ch_thr(0), v); chk("R1 thr0", v, 0);
        rd(ch_ctl(3), v); chk("R1 ctl3", v, 0);

        // R2: channel count
        rd(8'h04, v); chk("R2 info", v, NCH);

        // R11: unmapped and out-of-range reads
        rd(8'h08, v); chk("R11 unmapped", v, 0);
        rd(8'h40, v); chk("R11 beyond channels", v, 0);
        rd(8'h22, v); chk("R11 misaligned", v, 0);
        wr(ch_ctl(3), 32'h38);
        rd(ch_ctl(3), v); chk("R11 ctl readback", v, 32'h38);

        // R5: immediate writes while stopped
        wr(8'h18, 32'd9);
        rd(8'h18, v); chk("R5 period", v, 9);
        wr(ch_thr(2), 32'd33);
        rd(ch_thr(2), v); chk("R5 threshold", v, 33);

        // R4: stopped counter holds, counter loadable, codes 2/3 stop
        wr(8'h14, 32'd5);
        repeat (10) @(negedge clk);
        rd(8'h14, v); chk("R4 hold mode0", v, 5);
        wr(8'h10, 32'h10);
        repeat (10) @(negedge clk);
        rd(8'h14, v); chk("R4 hold mode2", v, 5);
        wr(8'h10, 32'h18);
        repeat (10) @(negedge clk);
        rd(8'h14, v); chk("R4 hold mode3", v, 5);

        // R3: prescaler sweep, period 3, threshold 2
        for (int ps = 0; ps < 4; ps++) begin
            stop_and_clear(3);
            wr(ch_thr(0), 32'd2);
            wr(ch_ctl(0), 32'h08);
            wr(8'h10, 32'(8 | ps));
            repeat (4) @(negedge clk);
            count_high(4 << ps, hi);
            chk($sformatf("R3 prescale %0d high", ps), hi[0], 2 << ps);
        end

        // R8 / R9: threshold sweep, period 7
        wr(ch_ctl(0), 32'h08);
        wr(ch_ctl(1), 32'h04);
        wr(ch_ctl(2), 32'h00);
        wr(ch_ctl(3), 32'h0C);
        for (int c = 0; c < 10; c++) begin
            stop_and_clear(7);
            for (int k = 0; k < NCH; k++) wr(ch_thr(k), 32'(c));
            wr(8'h10, 32'h08);
            count_high(8, hi);
            chk($sformatf("R8 thr %0d normal", c), hi[0], (c < 8) ? c : 8);
            chk($sformatf("R9 thr %0d inverted", c), hi[1], 8 - ((c < 8) ? c : 8));
            chk($sformatf("R9 thr %0d level0", c), hi[2], 0);
            chk($sformatf("R9 thr %0d level3", c), hi[3], 0);
        end

        // R9: level change applies without waiting for the boundary
        stop_and_clear(7);
        wr(ch_thr(0), 32'd0);
        wr(ch_ctl(0), 32'h08);
        wr(8'h10, 32'h08);
        chk("R9 before polarity change", pwm_out[0], 0);
        wr(ch_ctl(0), 32'h04);
        chk("R9 polarity immediate", pwm_out[0], 1);

        // R6: buffered writes while running
        stop_and_clear(15);
        wr(ch_thr(0), 32'd0);
        wr(ch_thr(1), 32'd12);
        wr(ch_ctl(1), 32'h88);
        wr(8'h10, 32'h08);
        wr(8'h18, 32'd3);
        wr(ch_thr(0), 32'd6);
        rd(8'h18, v); chk("R6 period held", v, 15);
        rd(ch_thr(0), v); chk("R6 threshold held", v, 0);
        repeat (20) @(negedge clk);
        rd(8'h18, v); chk("R6 period applied", v, 3);
        rd(ch_thr(0), v); chk("R6 threshold applied", v, 6);
        rd(ch_ctl(1), v); chk("R6 old period finished (flag at 12)", v, 32'h88);

        // R7: up/down counting, period 5, threshold 3
        stop_and_clear(5);
        wr(ch_thr(0), 32'd3);
        wr(ch_ctl(0), 32'h08);
        wr(8'h10, 32'h28);
        count_high(10, hi);
        chk("R7 center high count", hi[0], 5);
        wr(8'h18, 32'd2);
        rd(8'h18, v); chk("R7 period held", v, 5);
        repeat (20) @(negedge clk);
        rd(8'h18, v); chk("R7 period applied", v, 2);
        count_high(4, hi);
        chk("R7 new period full duty", hi[0], 4);

        // R10: flag behaviour
        stop_and_clear(7);
        wr(8'h14, 32'd3);
        wr(ch_thr(2), 32'd3);
        wr(ch_ctl(2), 32'h88);
        repeat (5) @(negedge clk);
        rd(ch_ctl(2), v); chk("R10 no set while stopped", v, 32'h08);
        wr(8'h10, 32'h08);
        repeat (10) @(negedge clk);
        wr(8'h10, 32'h00);
        rd(ch_ctl(2), v); chk("R10 set on match", v, 32'h88);
        repeat (5) @(negedge clk);
        rd(ch_ctl(2), v); chk("R10 sticky", v, 32'h88);
        wr(ch_ctl(2), 32'h88);
        rd(ch_ctl(2), v); chk("R10 write-one clear", v, 32'h08);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule